// File: doc/BRIEF.md
# Stage-3 to Stage-2 Operand Bypass

This block sits between the register file and the execute logic of a three-stage integer pipeline (fetch, decode/execute, memory/writeback). It looks at the instruction word in the decode/execute stage and at the instruction word in the memory/writeback stage. When the older instruction is about to write a register that the younger one reads, it replaces the stale register-file value with the final writeback value of the older one. A dependent pair therefore runs back to back with no bubble.

The block is purely combinational. It serves three consumers: ALU operand A (the rs1 value), ALU operand B, and the data of a store. Operand B takes the decoded immediate whenever the decode-stage format calls for one. The store-data path is judged on its own, so a store can take an immediate address offset on operand B while its data comes from the bypass. A bubble, a non-writing instruction, a destination of x0 or an active memory stall blocks the bypass.

Top module: `fwd_unit`

## Requirements
- R1: `fwd_a` is 1 when all of the following hold: stage 3 writes a register, its rd (bits 11:7) is nonzero, that rd equals stage-2 rs1 (bits 19:15), and stage 2 reads rs1. `op_a` then equals `wb_data_s3`.
- R2: `fwd_b` is 1 under the same conditions, applied to rs2 (bits 24:20), when stage 2 is OP (0110011) or BRANCH (1100011). `op_b` then equals `wb_data_s3`.
- R3: No select is raised when the stage-3 rd is x0.
- R4: Stage 3 writes a register only when `valid_s3` is 1 and its opcode (bits 6:0) is one of the following: OP, OP-IMM 0010011, LOAD 0000011, LUI 0110111, AUIPC 0010111, JAL 1101111, JALR 1100111, or SYSTEM 1110011 with funct3 (bits 14:12) nonzero. STORE 0100011, BRANCH, FENCE 0001111, SYSTEM with funct3 zero, and invalid slots never forward.
- R5: While `stall` is 1, all three selects are 0 and every output carries register-file data.
- R6: Stage 2 reads rs1 for OP, OP-IMM, LOAD, STORE, BRANCH, JALR, and for SYSTEM with funct3 of 001, 010 or 011. It reads rs2 only for OP, BRANCH and STORE. LUI, AUIPC and JAL read neither, so a field that merely matches causes no forward.
- R7: For any stage-2 opcode other than OP and BRANCH, `op_b` is the sign-extended immediate, whatever the rs2 field holds. The immediate format depends on the opcode: store format for STORE, upper format (bits 31:12, low 12 bits zero) for LUI and AUIPC, jump format for JAL, and the 12-bit form of bits 31:20 for all others.
- R8: `fwd_sd` is 1 when stage 2 is STORE and the R1 conditions hold for rs2. `store_data` then equals `wb_data_s3`. This is independent of `op_b`.
- R9: With its select at 0, `op_a` equals `rf_rs1_data`, and both `op_b` (for OP/BRANCH) and `store_data` equal `rf_rs2_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inst_s2 | input | 32 | Instruction word in decode/execute |
| inst_s3 | input | 32 | Instruction word in memory/writeback |
| valid_s3 | input | 1 | Stage 3 holds a live instruction (0 for bubble or flush) |
| stall | input | 1 | Memory stall in progress; blocks the bypass |
| wb_data_s3 | input | XLEN | Final writeback value of the stage-3 instruction |
| rf_rs1_data | input | XLEN | Register-file read of stage-2 rs1 |
| rf_rs2_data | input | XLEN | Register-file read of stage-2 rs2 |
| fwd_a | output | 1 | Operand A taken from the bypass |
| fwd_b | output | 1 | Operand B taken from the bypass |
| fwd_sd | output | 1 | Store data taken from the bypass |
| op_a | output | XLEN | ALU operand A |
| op_b | output | XLEN | ALU operand B |
| store_data | output | XLEN | Data for a stage-2 store |

## Verification
Random instruction pairs draw register numbers from a small pool that includes x0, so matches, misses and x0 destinations all occur often. Each pair is checked against a bench register-file model that tracks what each source architecturally holds. The random opcode mix covers writing and non-writing stage-3 instructions, SYSTEM with funct3 zero and nonzero, and stage-2 formats that do and do not read each source. This separates a wrong opcode class from a wrong field compare. Directed pairs then target the cases that are easiest to confuse:
- dual matches on rs1 and rs2;
- a store whose data is forwarded while operand B stays on its offset;
- an upper-immediate instruction with a coincidental field match;
- a stall;
- a bubble.

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input  logic [31:0]     inst_s2,
  input  logic [31:0]     inst_s3,
  input  logic            valid_s3,
  input  logic            stall,
  input  logic [XLEN-1:0] wb_data_s3,
  input  logic [XLEN-1:0] rf_rs1_data,
  input  logic [XLEN-1:0] rf_rs2_data,
  output logic            fwd_a,
  output logic            fwd_b,
  output logic            fwd_sd,
  output logic [XLEN-1:0] op_a,
  output logic [XLEN-1:0] op_b,
  output logic [XLEN-1:0] store_data
);
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_SYS    = 7'b1110011;

  logic [6:0]     opc2, opc3;
  logic [2:0]     f3_2, f3_3;
  logic [RAW-1:0] rd3, rs1_2, rs2_2;
  logic           wr3, live3, rd1_used, rd2_used, alu_rs2, is_st;
  logic [31:0]    imm;

  assign opc2  = inst_s2[6:0];
  assign opc3  = inst_s3[6:0];
  assign f3_2  = inst_s2[14:12];
  assign f3_3  = inst_s3[14:12];
  assign rd3   = inst_s3[7 +: RAW];
  assign rs1_2 = inst_s2[15 +: RAW];
  assign rs2_2 = inst_s2[20 +: RAW];

  always_comb begin
    unique case (opc3)
      OPC_OP, OPC_OPIMM, OPC_LOAD, OPC_LUI,
      OPC_AUIPC, OPC_JAL, OPC_JALR: wr3 = 1'b1;
      OPC_SYS:                      wr3 = (f3_3 != 3'd0);
      default:                      wr3 = 1'b0;
    endcase
  end

  assign live3 = valid_s3 && wr3 && (rd3 != '0) && !stall;

  always_comb begin
    unique case (opc2)
      OPC_OP, OPC_OPIMM, OPC_LOAD, OPC_STORE,
      OPC_BRANCH, OPC_JALR: rd1_used = 1'b1;
      OPC_SYS:              rd1_used = (f3_2 != 3'd0) && !f3_2[2];
      default:              rd1_used = 1'b0;
    endcase
  end

  assign alu_rs2  = (opc2 == OPC_OP) || (opc2 == OPC_BRANCH);
  assign is_st    = (opc2 == OPC_STORE);
  assign rd2_used = alu_rs2 || is_st;

  always_comb begin
    unique case (opc2)
      OPC_STORE:          imm = {{20{inst_s2[31]}}, inst_s2[31:25], inst_s2[11:7]};
      OPC_LUI, OPC_AUIPC: imm = {inst_s2[31:12], 12'd0};
      OPC_JAL:            imm = {{11{inst_s2[31]}}, inst_s2[31], inst_s2[19:12],
                                 inst_s2[20], inst_s2[30:21], 1'b0};
      default:            imm = {{20{inst_s2[31]}}, inst_s2[31:20]};
    endcase
  end

  assign fwd_a  = live3 && rd1_used && (rd3 == rs1_2);
  assign fwd_b  = live3 && alu_rs2 && (rd3 == rs2_2);
  assign fwd_sd = live3 && is_st && (rd3 == rs2_2);

  assign op_a       = fwd_a ? wb_data_s3 : rf_rs1_data;
  assign store_data = fwd_sd ? wb_data_s3 : rf_rs2_data;
  assign op_b       = !alu_rs2 ? XLEN'($signed(imm)) :
                      fwd_b    ? wb_data_s3 : rf_rs2_data;

  always_comb begin
    p_fwd_a_value_r1: assert (!fwd_a || op_a == wb_data_s3);
    p_fwd_b_value_r2: assert (!fwd_b || op_b == wb_data_s3);
    p_x0_blocks_r3: assert (rd3 != '0 || !(fwd_a || fwd_b || fwd_sd));
    p_bubble_blocks_r4: assert (valid_s3 || !(fwd_a || fwd_b || fwd_sd));
    p_stall_blocks_r5: assert (!stall || $countones({fwd_a, fwd_b, fwd_sd}) == 0);
    p_sd_b_exclusive_r8: assert ($onehot0({fwd_b, fwd_sd}));
    p_sd_value_r8: assert (!fwd_sd || store_data == wb_data_s3);
    p_rf_a_r9: assert (fwd_a || op_a == rf_rs1_data);
  end
endmodule

// File: tb/tb_fwd_unit.sv
module tb_fwd_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] inst_s2, inst_s3, wb_data_s3, rf_rs1_data, rf_rs2_data;
  logic        valid_s3, stall;
  logic        fwd_a, fwd_b, fwd_sd;
  logic [31:0] op_a, op_b, store_data;

  fwd_unit dut (
    .inst_s2(inst_s2), .inst_s3(inst_s3), .valid_s3(valid_s3), .stall(stall),
    .wb_data_s3(wb_data_s3), .rf_rs1_data(rf_rs1_data), .rf_rs2_data(rf_rs2_data),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_sd(fwd_sd),
    .op_a(op_a), .op_b(op_b), .store_data(store_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] regs [32];
  logic [6:0] opcs [11] = '{7'b0110011, 7'b0010011, 7'b0000011, 7'b0100011,
                            7'b1100011, 7'b0110111, 7'b0010111, 7'b1101111,
                            7'b1100111, 7'b1110011, 7'b0001111};

  function automatic logic writes_reg(input logic [31:0] w);
    case (w[6:0])
      7'b1110011: return w[14:12] != 0;
      7'b0110011, 7'b0010011, 7'b0000011, 7'b0110111,
      7'b0010111, 7'b1101111, 7'b1100111: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic reads1(input logic [31:0] w);
    if (w[6:0] == 7'b1110011) return w[14:12] inside {3'd1, 3'd2, 3'd3};
    return w[6:0] inside {7'b0110011, 7'b0010011, 7'b0000011, 7'b0100011,
                          7'b1100011, 7'b1100111};
  endfunction

  function automatic logic [31:0] ref_imm(input logic [31:0] w);
    logic [31:0] s;
    s = {32{w[31]}};
    case (w[6:0])
      7'b0100011: return {s[31:12], w[31:25], w[11:7]};
      7'b0110111, 7'b0010111: return {w[31:12], 12'h000};
      7'b1101111: return {s[31:21], w[31], w[19:12], w[20], w[30:21], 1'b0};
      default: return {s[31:12], w[31:20]};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] i2, input logic [31:0] i3, input logic v,
                       input logic st, input logic [31:0] wb);
    logic [4:0] r1, r2, d;
    logic hit, alu2, str, e_a, e_b, e_sd;
    logic [31:0] ea, eb, esd;
    r1 = i2[19:15]; r2 = i2[24:20]; d = i3[11:7];
    @(posedge clk); #1;
    inst_s2 = i2; inst_s3 = i3; valid_s3 = v; stall = st; wb_data_s3 = wb;
    rf_rs1_data = regs[r1]; rf_rs2_data = regs[r2];
    hit = v && !st && writes_reg(i3) && d != 0;
    alu2 = i2[6:0] == 7'b0110011 || i2[6:0] == 7'b1100011;
    str = i2[6:0] == 7'b0100011;
    e_a = hit && reads1(i2) && d == r1;
    e_b = hit && alu2 && d == r2;
    e_sd = hit && str && d == r2;
    ea = e_a ? wb : regs[r1];
    eb = alu2 ? (e_b ? wb : regs[r2]) : ref_imm(i2);
    esd = e_sd ? wb : regs[r2];
    @(negedge clk);
    chk("R1/R3/R4/R5/R6 fwd_a", {31'd0, fwd_a}, {31'd0, e_a});
    chk("R2/R3/R4/R5 fwd_b", {31'd0, fwd_b}, {31'd0, e_b});
    chk("R8/R3/R4/R5 fwd_sd", {31'd0, fwd_sd}, {31'd0, e_sd});
    chk("R1/R9 op_a", op_a, ea);
    chk("R2/R7/R9 op_b", op_b, eb);
    chk("R8/R9 store_data", store_data, esd);
    if (hit) regs[d] = wb;
  endtask

  function automatic logic [31:0] mk(input logic [6:0] op, input logic [4:0] rd,
                                     input logic [4:0] a, input logic [4:0] b,
                                     input logic [2:0] f3, input logic [6:0] hi);
    return {hi, b, a, f3, rd, op};
  endfunction

  initial begin
    #400000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5c));
    inst_s2 = 0; inst_s3 = 0; valid_s3 = 0; stall = 0;
    wb_data_s3 = 0; rf_rs1_data = 0; rf_rs2_data = 0;
    for (int i = 0; i < 32; i++) regs[i] = (i == 0) ? 32'd0 : 32'h1000_0000 + i;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset fwd_a", {31'd0, fwd_a}, 32'd0);
    chk("R9 reset fwd_sd", {31'd0, fwd_sd}, 32'd0);

    // R1 R2: both sources hit
    apply(mk(7'b0110011, 5'd7, 5'd5, 5'd5, 3'd0, 7'd0), mk(7'b0110011, 5'd5, 5'd1, 5'd2, 3'd0, 7'd0), 1, 0, 32'hCAFE_0001);
    // R3: x0 destination
    apply(mk(7'b0110011, 5'd7, 5'd0, 5'd0, 3'd0, 7'd0), mk(7'b0010011, 5'd0, 5'd1, 5'd0, 3'd0, 7'd0), 1, 0, 32'hDEAD_0000);
    // R4: store in stage 3
    apply(mk(7'b0110011, 5'd7, 5'd6, 5'd6, 3'd0, 7'd0), mk(7'b0100011, 5'd6, 5'd1, 5'd2, 3'd2, 7'd0), 1, 0, 32'hBAD0_0006);
    // R4: bubble
    apply(mk(7'b0110011, 5'd7, 5'd6, 5'd6, 3'd0, 7'd0), mk(7'b0110011, 5'd6, 5'd1, 5'd2, 3'd0, 7'd0), 0, 0, 32'hBAD1_0006);
    // R5: stall
    apply(mk(7'b0110011, 5'd7, 5'd6, 5'd6, 3'd0, 7'd0), mk(7'b0110011, 5'd6, 5'd1, 5'd2, 3'd0, 7'd0), 1, 1, 32'hBAD2_0006);
    // R8 R7: store data forwarded, op_b keeps offset
    apply(mk(7'b0100011, 5'd3, 5'd9, 5'd8, 3'd2, 7'h7F), mk(7'b0000011, 5'd8, 5'd1, 5'd0, 3'd2, 7'd0), 1, 0, 32'h5151_0008);
    // R6: LUI with matching fields
    apply(mk(7'b0110111, 5'd3, 5'd8, 5'd8, 3'd5, 7'h12), mk(7'b0110011, 5'd8, 5'd1, 5'd2, 3'd0, 7'd0), 1, 0, 32'h7777_0008);
    // R4: SYSTEM with funct3 zero
    apply(mk(7'b0110011, 5'd3, 5'd4, 5'd4, 3'd0, 7'd0), mk(7'b1110011, 5'd4, 5'd0, 5'd0, 3'd0, 7'd0), 1, 0, 32'h8888_0004);

    for (int k = 0; k < 3000; k++) begin
      logic [31:0] a, b;
      logic [4:0] pool [5] = '{5'd0, 5'd1, 5'd2, 5'd3, 5'd31};
      a = mk(opcs[$urandom_range(10)], pool[$urandom_range(4)], pool[$urandom_range(4)],
             pool[$urandom_range(4)], 3'($urandom_range(7)), 7'($urandom));
      b = mk(opcs[$urandom_range(10)], pool[$urandom_range(4)], pool[$urandom_range(4)],
             pool[$urandom_range(4)], 3'($urandom_range(7)), 7'($urandom));
      apply(a, b, $urandom_range(7) != 0, $urandom_range(9) == 0, $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule